// File: doc/BRIEF.md
# Atomic Fetch-and-Add Unit

This block carries out one indivisible fetch-and-add on a 64-bit-wide, word-addressed memory port. A requester presents a byte address, an operand size of four or eight bytes, a three-bit selector that picks one of eight signed increments, an ordering type, and the attributes of the page: read permission, write permission and memory type. The unit screens the command for page-type, alignment and permission faults. A clean command becomes a locked read followed by a byte-masked write of the sum to the same word.

The response returns the old operand value, zero-extended to 64 bits, with its poison flag cleared. A faulting command returns a fault code instead and never touches memory. The ordering type is echoed with every response so that a separate ordering unit can place the operation relative to older and younger data accesses.

Top module: `fetch_add_unit`

## Requirements
- R1: The response data is the pre-add operand, zero-extended to 64 bits. When `cmd_size8`=1 this is the whole word. When `cmd_size8`=0 it is the 32-bit half selected by address bit 2 (1 selects bits 63:32). `rsp_poison` is 0 on every response.
- R2: `cmd_inc_sel` values 0 to 7 select the increments -16, -8, -4, -1, +1, +4, +8, +16. The increment is sign-extended before it is added.
- R3: The write stores only the low 4 or 8 bytes of the sum, and any carry beyond the operand is dropped. An 8-byte write uses `mem_be`=8'hFF. A 4-byte write uses 8'h0F for the low half and 8'hF0 for the high half, so the other half of the word is unchanged.
- R4: An address that is not a multiple of the operand size gives fault code 3 (unaligned).
- R5: A page that lacks read permission or lacks write permission gives fault code 4 (permission).
- R6: `cmd_mtype` uses these codes: 0 = cacheable write-back, 1 = uncacheable exported, 2 = poisoned page, 3 = any other type. Only types 0 and 1 may execute. Type 2 gives fault code 1. Type 3 gives fault code 2.
- R7: When several faults apply, the order of precedence is: poisoned page (1), then unsupported type (2), then unaligned (3), then permission (4). Fault code 0 means success.
- R8: A faulting command makes no memory access. Its response appears in the cycle after it is accepted, and `cmd_ready` stays high.
- R9: An accepted clean command issues a read in the next cycle and a write to the same word in the cycle after that. `mem_lock` is high in both cycles.
- R10: `cmd_ready` is low from the cycle after acceptance until the write has been issued. The success response and `cmd_ready` both return in the cycle after the write.
- R11: `rsp_release` equals the command's `cmd_release` (1 = release, 0 = acquire) on every response.
- R12: After a synchronous reset, `cmd_ready` is 1, and `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_addr | input | ADDR_W | Byte address of the operand |
| cmd_size8 | input | 1 | 1 = 8-byte operand, 0 = 4-byte operand |
| cmd_inc_sel | input | 3 | Increment selector |
| cmd_release | input | 1 | 1 = release ordering, 0 = acquire |
| cmd_perm_rd | input | 1 | Page allows reads |
| cmd_perm_wr | input | 1 | Page allows writes |
| cmd_mtype | input | 2 | Page memory type |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Locks memory against other requesters |
| mem_word_addr | output | ADDR_W-3 | 64-bit word address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables for the write |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 3 | Fault code, 0 for success |
| rsp_data | output | 64 | Zero-extended old value |
| rsp_poison | output | 1 | Poison flag of the result |
| rsp_release | output | 1 | Echoed ordering type |

## Verification
The assertions check the following on every cycle:
- A memory request always carries the lock.
- A read is always followed by a write to the same word.
- `cmd_ready` stays low while an access is in flight.
- Every write is followed by a success response.
- The byte enables on a write select a whole word or exactly one half.
- A fault response never coincides with a memory request.

Only the bench scenarios can show the arithmetic and the stored contents. This covers wrap-around in both directions, carries that are dropped at the 32-bit boundary, the untouched neighbouring half, all eight increment codes, and which fault wins when several apply at once.

// File: rtl/fau_pkg.sv
package fau_pkg;
  typedef enum logic [1:0] {
    MT_WB    = 2'd0,
    MT_UCX   = 2'd1,
    MT_POISON = 2'd2,
    MT_OTHER = 2'd3
  } mtype_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_POISON = 3'd1,
    FLT_UNSUP  = 3'd2,
    FLT_ALIGN  = 3'd3,
    FLT_PERM   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } state_e;
endpackage

// File: rtl/fau_fault_chk.sv
module fau_fault_chk
  import fau_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  logic       size8,
  input  logic       perm_rd,
  input  logic       perm_wr,
  input  mtype_e     mtype,
  output fault_e     fault
);
  logic misaligned;

  assign misaligned = size8 ? (addr_lo != 3'd0) : (addr_lo[1:0] != 2'd0);

  always_comb begin
    if (mtype == MT_POISON)          fault = FLT_POISON;
    else if (mtype == MT_OTHER)      fault = FLT_UNSUP;
    else if (misaligned)             fault = FLT_ALIGN;
    else if (!(perm_rd && perm_wr))  fault = FLT_PERM;
    else                             fault = FLT_NONE;
  end
endmodule

// File: rtl/fau_lane_add.sv
module fau_lane_add #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   rdata,
  input  logic                size8,
  input  logic                hi_sel,
  input  logic [2:0]          inc_sel,
  output logic [DATA_W-1:0]   old_val,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] be
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BE_W   = DATA_W / 8;
  localparam int HBE_W  = BE_W / 2;

  logic [7:0]        inc8;
  logic [DATA_W-1:0] inc_ext;
  logic [DATA_W-1:0] sum;
  logic [HALF_W-1:0] half;

  always_comb begin
    case (inc_sel)
      3'd0:    inc8 = 8'hF0;
      3'd1:    inc8 = 8'hF8;
      3'd2:    inc8 = 8'hFC;
      3'd3:    inc8 = 8'hFF;
      3'd4:    inc8 = 8'h01;
      3'd5:    inc8 = 8'h04;
      3'd6:    inc8 = 8'h08;
      default: inc8 = 8'h10;
    endcase
  end

  assign inc_ext = {{(DATA_W-8){inc8[7]}}, inc8};
  assign half    = hi_sel ? rdata[DATA_W-1:HALF_W] : rdata[HALF_W-1:0];
  assign old_val = size8 ? rdata : {{HALF_W{1'b0}}, half};
  assign sum     = old_val + inc_ext;
  assign wdata   = size8 ? sum : {sum[HALF_W-1:0], sum[HALF_W-1:0]};
  assign be      = size8 ? {BE_W{1'b1}}
                 : (hi_sel ? {{HBE_W{1'b1}}, {HBE_W{1'b0}}}
                           : {{HBE_W{1'b0}}, {HBE_W{1'b1}}});
endmodule

// File: rtl/fetch_add_unit.sv
module fetch_add_unit
  import fau_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_size8,
  input  logic [2:0]        cmd_inc_sel,
  input  logic              cmd_release,
  input  logic              cmd_perm_rd,
  input  logic              cmd_perm_wr,
  input  logic [1:0]        cmd_mtype,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-4:0] mem_word_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic [63:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [63:0]       rsp_data,
  output logic              rsp_poison,
  output logic              rsp_release
);
  localparam int DATA_W  = 64;
  localparam int BE_W    = DATA_W / 8;
  localparam int WORD_AW = ADDR_W - 3;

  state_e              state;
  logic [WORD_AW-1:0]  q_word;
  logic                q_hi;
  logic                q_size8;
  logic [2:0]          q_inc;
  logic                q_rel;
  fault_e              chk_fault;
  fault_e              rsp_fault_q;
  logic [DATA_W-1:0]   lane_old;
  logic [DATA_W-1:0]   lane_wdata;
  logic [BE_W-1:0]     lane_be;

  fau_fault_chk u_chk (
    .addr_lo (cmd_addr[2:0]),
    .size8   (cmd_size8),
    .perm_rd (cmd_perm_rd),
    .perm_wr (cmd_perm_wr),
    .mtype   (mtype_e'(cmd_mtype)),
    .fault   (chk_fault)
  );

  fau_lane_add #(.DATA_W(DATA_W)) u_lane (
    .rdata   (mem_rdata),
    .size8   (q_size8),
    .hi_sel  (q_hi),
    .inc_sel (q_inc),
    .old_val (lane_old),
    .wdata   (lane_wdata),
    .be      (lane_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      q_word      <= '0;
      q_hi        <= 1'b0;
      q_size8     <= 1'b0;
      q_inc       <= '0;
      q_rel       <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_fault_q <= FLT_NONE;
      rsp_data    <= '0;
      rsp_release <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            q_word  <= cmd_addr[ADDR_W-1:3];
            q_hi    <= cmd_addr[2];
            q_size8 <= cmd_size8;
            q_inc   <= cmd_inc_sel;
            q_rel   <= cmd_release;
            if (chk_fault != FLT_NONE) begin
              rsp_valid   <= 1'b1;
              rsp_fault_q <= chk_fault;
              rsp_data    <= '0;
              rsp_release <= cmd_release;
            end else begin
              state <= ST_RD;
            end
          end
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          state       <= ST_IDLE;
          rsp_valid   <= 1'b1;
          rsp_fault_q <= FLT_NONE;
          rsp_data    <= lane_old;
          rsp_release <= q_rel;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == ST_IDLE);
  assign mem_req       = (state == ST_RD) || (state == ST_WR);
  assign mem_we        = (state == ST_WR);
  assign mem_lock      = mem_req;
  assign mem_word_addr = q_word;
  assign mem_wdata     = mem_we ? lane_wdata : '0;
  assign mem_be        = mem_we ? lane_be : '0;
  assign rsp_fault     = rsp_fault_q;
  assign rsp_poison    = 1'b0;
endmodule

// File: rtl/fau_sva.sv
module fau_sva #(
  parameter int WORD_AW = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_ready,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_lock,
  input logic [WORD_AW-1:0] mem_word_addr,
  input logic [7:0]         mem_be,
  input logic               rsp_valid,
  input logic [2:0]         rsp_fault
);
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_lock); // R9

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> (mem_req && mem_we && $stable(mem_word_addr))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready); // R10

  AST_WRITE_THEN_RSP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> (rsp_valid && rsp_fault == 3'd0 && cmd_ready)); // R10

  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (!mem_req && cmd_ready)); // R8

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be == 8'hFF || mem_be == 8'h0F || mem_be == 8'hF0)); // R3
endmodule

bind fetch_add_unit fau_sva #(.WORD_AW(ADDR_W-3)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .cmd_ready     (cmd_ready),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_lock      (mem_lock),
  .mem_word_addr (mem_word_addr),
  .mem_be        (mem_be),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault)
);

// File: tb/fetch_add_unit_tb.sv
`timescale 1ns/1ps
module fetch_add_unit_tb;
  localparam int AW    = 8;
  localparam int WORDS = 1 << (AW - 3);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_size8 = 1'b0;
  logic [2:0]    cmd_inc_sel = '0;
  logic          cmd_release = 1'b0;
  logic          cmd_perm_rd = 1'b0;
  logic          cmd_perm_wr = 1'b0;
  logic [1:0]    cmd_mtype = '0;
  logic          mem_req, mem_we, mem_lock;
  logic [AW-4:0] mem_word_addr;
  logic [63:0]   mem_wdata;
  logic [7:0]    mem_be;
  logic [63:0]   mem_rdata = '0;
  logic          rsp_valid;
  logic [2:0]    rsp_fault;
  logic [63:0]   rsp_data;
  logic          rsp_poison, rsp_release;

  logic [63:0] bmem [WORDS];
  logic [63:0] refm [WORDS];
  int incs [8] = '{-16, -8, -4, -1, 1, 4, 8, 16};
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fetch_add_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_size8(cmd_size8), .cmd_inc_sel(cmd_inc_sel),
    .cmd_release(cmd_release), .cmd_perm_rd(cmd_perm_rd), .cmd_perm_wr(cmd_perm_wr),
    .cmd_mtype(cmd_mtype), .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_word_addr(mem_word_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_data(rsp_data), .rsp_poison(rsp_poison), .rsp_release(rsp_release)
  );

  // memory responder: registered read, byte-masked write
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= bmem[mem_word_addr];
    if (mem_req && mem_we)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) bmem[mem_word_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_fault(logic [AW-1:0] a, bit s8, bit rd, bit wr, logic [1:0] mt);
    bit mis = s8 ? (a[2:0] != 0) : (a[1:0] != 0);
    if (mt == 2'd2) return 3'd1;
    if (mt == 2'd3) return 3'd2;
    if (mis) return 3'd3;
    if (!(rd && wr)) return 3'd4;
    return 3'd0;
  endfunction

  task automatic do_op(string tag, logic [AW-1:0] a, bit s8, int sel, bit rel,
                       bit rd = 1, bit wr = 1, logic [1:0] mt = 2'd0);
    logic [2:0]  ef;
    logic [63:0] w, oldv, sum, nw;
    int          wa;
    longint      li;
    wa = int'(a[AW-1:3]);
    ef = ref_fault(a, s8, rd, wr, mt);
    w  = refm[wa];
    oldv = s8 ? w : (a[2] ? {32'h0, w[63:32]} : {32'h0, w[31:0]});
    li  = incs[sel];
    sum = oldv + 64'(li);
    nw  = s8 ? sum : (a[2] ? {sum[31:0], w[31:0]} : {w[63:32], sum[31:0]});
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_size8 = s8; cmd_inc_sel = 3'(sel);
    cmd_release = rel; cmd_perm_rd = rd; cmd_perm_wr = wr; cmd_mtype = mt;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (ef != 0) begin
      chk({tag, " R7 fault code"}, 64'(rsp_fault), 64'(ef));
      chk({tag, " R8 rsp next cycle, no access, ready"},
          {61'h0, rsp_valid, mem_req, cmd_ready}, {61'h0, 3'b101});
      chk({tag, " R11 order flag"}, 64'(rsp_release), 64'(rel));
      @(negedge clk);
      chk({tag, " R8 memory unchanged"}, bmem[wa], refm[wa]);
    end else begin
      chk({tag, " R9 read cycle req/we/lock/ready/rsp"},
          {59'h0, mem_req, mem_we, mem_lock, cmd_ready, rsp_valid}, {59'h0, 5'b10100});
      chk({tag, " R9 read addr"}, 64'(mem_word_addr), 64'(wa));
      @(negedge clk);
      chk({tag, " R9 write cycle req/we/lock/ready/rsp"},
          {59'h0, mem_req, mem_we, mem_lock, cmd_ready, rsp_valid}, {59'h0, 5'b11100});
      chk({tag, " R9 write addr"}, 64'(mem_word_addr), 64'(wa));
      chk({tag, " R3 byte enables"}, 64'(mem_be), s8 ? 64'hFF : (a[2] ? 64'hF0 : 64'h0F));
      @(negedge clk);
      chk({tag, " R10 rsp valid, ready back, no req"},
          {61'h0, rsp_valid, cmd_ready, mem_req}, {61'h0, 3'b110});
      chk({tag, " R7 no fault"}, 64'(rsp_fault), 64'h0);
      chk({tag, " R1 old value"}, rsp_data, oldv);
      chk({tag, " R1 poison cleared"}, 64'(rsp_poison), 64'h0);
      chk({tag, " R11 order flag"}, 64'(rsp_release), 64'(rel));
      chk({tag, " R3 stored word"}, bmem[wa], nw);
      refm[wa] = nw;
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      bmem[i] = {32'hA5A5_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
      refm[i] = bmem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 reset ready/rsp/req", {61'h0, cmd_ready, rsp_valid, mem_req}, {61'h0, 3'b100});
    rst = 0;
    @(negedge clk);
    chk("R12 idle after reset", {61'h0, cmd_ready, rsp_valid, mem_req}, {61'h0, 3'b100});

    // R1 R2 R3 eight-byte add
    do_op("R2 8B +16", 8'h08, 1, 7, 0);
    bmem[2] = 64'h5; refm[2] = 64'h5;
    do_op("R2 8B -16 wrap", 8'h10, 1, 0, 1);
    // R3 four-byte low half borrow, high half preserved
    bmem[3] = 64'hCAFE_F00D_0000_0000; refm[3] = bmem[3];
    do_op("R3 4B low -1", 8'h18, 0, 3, 0);
    // R3 four-byte high half carry dropped, low half preserved
    bmem[4] = 64'hFFFF_FFF8_1111_2222; refm[4] = bmem[4];
    do_op("R3 4B high +16 carry", 8'h24, 0, 7, 1);
    // R2 every selector, both sizes
    for (int s = 0; s < 8; s++) begin
      do_op("R2 sweep 8B", 8'h40, 1, s, s[0]);
      do_op("R2 sweep 4B hi", 8'h4C, 0, s, 0);
    end
    // R6 uncacheable exported executes
    do_op("R6 exported ok", 8'h50, 1, 4, 0, 1, 1, 2'd1);
    // faults
    do_op("R6 poisoned page", 8'h58, 1, 4, 0, 1, 1, 2'd2);
    do_op("R6 unsupported type", 8'h58, 1, 4, 1, 1, 1, 2'd3);
    do_op("R7 poison beats misalign+perm", 8'h5B, 1, 4, 0, 0, 0, 2'd2);
    do_op("R7 unsup beats misalign", 8'h5A, 0, 4, 0, 1, 1, 2'd3);
    do_op("R4 8B at +4", 8'h5C, 1, 4, 0);
    do_op("R4 4B at +2", 8'h5A, 0, 4, 1);
    do_op("R7 align beats perm", 8'h59, 0, 4, 0, 0, 1);
    do_op("R5 no write perm", 8'h60, 1, 4, 0, 1, 0);
    do_op("R5 no read perm", 8'h64, 0, 4, 1, 0, 1);
    // back-to-back after fault
    do_op("R8 clean after fault", 8'h60, 1, 5, 0);

    for (int i = 0; i < WORDS; i++)
      chk("R3 final memory image", bmem[i], refm[i]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule